// File: doc/BRIEF.md
# Region Protection Checker

This block sits beside a memory access path and checks every access against a small set of programmable address windows. Each access arrives with an address and three attributes: whether it writes, whether it is an instruction fetch, and whether the requester runs privileged. One clock later the block answers with an allow or fault verdict. With the verdict it reports which window matched and that window's cacheable, bufferable and shareable attributes.

Each window is a naturally aligned power-of-two span. Its size is coded as log2 of the byte count minus one. The span can be cut into eight equal parts, and any of those parts can be switched off. A window also carries an access-permission code and a no-execute bit.

Software programs the windows through a small write-only register port. A select register chooses the window, and then base and attribute writes go to it. A control register holds a master enable and a flag that lets privileged requests fall back to a permissive default map when they hit no window.

Top module: `rgn_guard`

## Requirements
- R1: After a synchronous reset, every response output is low, all windows are disabled, and the control register holds zero.
- R2: While the master enable (control bit 0) is 0, every valid access is allowed, with the hit flag low and the cacheable, bufferable and shareable outputs all 0.
- R3: A window matches when its enable (attribute bit 0) is set and the address equals the base, with the low SIZE+1 bits of both ignored. SIZE sits in attribute bits 5:1. SIZE 31 covers the full 4 GiB space and SIZE 17 covers 256 KiB.
- R4: When several enabled windows match, the one with the highest index decides, and that index is reported on rsp_region.
- R5: For SIZE 7 or more, the window splits into eight equal parts, and setting attribute bit 8+k removes part k from the window. An address in a removed part is then judged by the next lower matching window.
- R6: The permission code in attribute bits 26:24 is decoded as privileged/unprivileged rights:
  - 0 and 4 give none/none.
  - 1 gives read-write/none.
  - 2 gives read-write/read-only.
  - 3 gives read-write/read-write.
  - 5 gives read-only/none.
  - 6 and 7 give read-only/read-only.
  
  A write needs write rights, and a read needs at least read rights.
- R7: An instruction fetch is allowed only if the window grants read rights and its no-execute bit (attribute bit 28) is 0.
- R8: With the master enable set and no window matching, a privileged access is allowed only if control bit 1 is set. An unprivileged access always faults.
- R9: When a window decides, rsp_hit is 1 and rsp_cacheable, rsp_bufferable and rsp_shareable repeat that window's attribute bits 17, 16 and 18, whether the access is allowed or not. With no hit, those three outputs are 0.
- R10: Register writes use cfg_addr:
  - 0 writes control.
  - 1 writes the window select.
  - 2 writes the selected window's base.
  - 3 writes the selected window's attributes.
- R11: The verdict for an access presented in one cycle appears on the outputs after the next rising edge. A register write in the same cycle as an access affects only later accesses.
- R12: When no access was presented, rsp_valid, rsp_allow, rsp_fault and rsp_hit are 0. When one was, exactly one of rsp_allow and rsp_fault is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: control, window select, base, attributes |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access refused |
| rsp_hit | output | 1 | A window decided the verdict |
| rsp_region | output | 3 | Index of the deciding window |
| rsp_cacheable | output | 1 | Deciding window's cacheable attribute |
| rsp_bufferable | output | 1 | Deciding window's bufferable attribute |
| rsp_shareable | output | 1 | Deciding window's shareable attribute |

## Verification
A register write and an access check can land in the same cycle. The bench provokes this by raising cfg_we with a new attribute word for a window while it also presents an access inside that window. The verdict must reflect the old permission code. The same access repeated one cycle later must reflect the new code.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

  parameter int ADDR_W = 32;
  localparam int SIZE_W = 5;
  localparam int SRD_W  = 8;
  localparam int AP_W   = 3;

  // attribute word field positions (decoded by software-visible layout)
  localparam int POS_XN   = 28;
  localparam int POS_AP   = 24;
  localparam int POS_SHR  = 18;
  localparam int POS_CCH  = 17;
  localparam int POS_BUF  = 16;
  localparam int POS_SRD  = 8;
  localparam int POS_SIZE = 1;
  localparam int POS_EN   = 0;

  // smallest size code that allows part removal
  localparam int SRD_MIN_SIZE = 7;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SEL  = 2'd1,
    REG_BASE = 2'd2,
    REG_ATTR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic              xn;
    logic [AP_W-1:0]   ap;
    logic              shr;
    logic              cch;
    logic              buf_en;
    logic [SRD_W-1:0]  srd;
    logic [SIZE_W-1:0] size;
    logic              en;
  } rgn_cfg_t;

  function automatic logic ap_read_ok(input logic [AP_W-1:0] ap, input logic priv);
    case (ap)
      3'd1:    return priv;
      3'd2:    return 1'b1;
      3'd3:    return 1'b1;
      3'd5:    return priv;
      3'd6:    return 1'b1;
      3'd7:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ap_write_ok(input logic [AP_W-1:0] ap, input logic priv);
    case (ap)
      3'd1:    return priv;
      3'd2:    return priv;
      3'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rgn_guard_regs.sv
module rgn_guard_regs
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int SEL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_addr,
  input  logic [ADDR_W-1:0]         cfg_wdata,
  output logic                      ctrl_en,
  output logic                      ctrl_pdef,
  output rgn_cfg_t [NUM_RGN-1:0]    cfg_o
);

  logic [SEL_W-1:0] sel_q;
  reg_sel_e         wsel;

  assign wsel = reg_sel_e'(cfg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ctrl_pdef <= 1'b0;
      sel_q     <= '0;
    end else if (cfg_we) begin
      case (wsel)
        REG_CTRL: begin
          ctrl_en   <= cfg_wdata[0];
          ctrl_pdef <= cfg_wdata[1];
        end
        REG_SEL:  sel_q <= cfg_wdata[SEL_W-1:0];
        default:  ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
    logic hit_sel;
    assign hit_sel = cfg_we && (sel_q == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[i] <= '0;
      end else if (hit_sel) begin
        if (wsel == REG_BASE) begin
          cfg_o[i].base <= cfg_wdata;
        end else if (wsel == REG_ATTR) begin
          cfg_o[i].xn     <= cfg_wdata[POS_XN];
          cfg_o[i].ap     <= cfg_wdata[POS_AP +: AP_W];
          cfg_o[i].shr    <= cfg_wdata[POS_SHR];
          cfg_o[i].cch    <= cfg_wdata[POS_CCH];
          cfg_o[i].buf_en <= cfg_wdata[POS_BUF];
          cfg_o[i].srd    <= cfg_wdata[POS_SRD +: SRD_W];
          cfg_o[i].size   <= cfg_wdata[POS_SIZE +: SIZE_W];
          cfg_o[i].en     <= cfg_wdata[POS_EN];
        end
      end
    end
  end

  // R10: a select write is captured for the following writes
  p_sel_capture_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd1) |=> (sel_q == $past(cfg_wdata[SEL_W-1:0])));

  // R10: control changes only through a control write
  p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_addr == 2'd0) |=> ($stable(ctrl_en) && $stable(ctrl_pdef)));

endmodule

// File: rtl/rgn_guard_match.sv
module rgn_guard_match
  import rgn_guard_pkg::*;
(
  input  rgn_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam int MW = ADDR_W + 1;

  logic [5:0]        lg;
  logic [5:0]        sub_sh;
  logic [MW-1:0]     span;
  logic [ADDR_W-1:0] mask;
  logic              in_span;
  logic [2:0]        sub_idx;
  logic              sub_off;

  always_comb begin
    lg      = {1'b0, cfg.size} + 6'd1;
    span    = (MW'(1) << lg) - MW'(1);
    mask    = ~span[ADDR_W-1:0];
    in_span = ((addr ^ cfg.base) & mask) == '0;
    sub_sh  = lg - 6'd3;
    sub_idx = 3'(addr >> sub_sh);
    sub_off = (cfg.size >= SIZE_W'(SRD_MIN_SIZE)) && cfg.srd[sub_idx];
    hit     = cfg.en && in_span && !sub_off;
  end

  // R3: a full-space window with no removed part catches every address
  always_comb begin
    if (cfg.en && cfg.size == '1 && cfg.srd == '0) begin
      p_full_space_r3: assert (hit);
    end
  end

  // R3: a disabled window never matches
  always_comb begin
    if (cfg.en == 1'b0) begin
      p_off_nomatch_r3: assert (!hit);
    end
  end

endmodule

// File: rtl/rgn_guard_decide.sv
module rgn_guard_decide
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int SEL_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic                   acc_fetch,
  input  logic                   acc_priv,
  input  logic                   ctrl_en,
  input  logic                   ctrl_pdef,
  input  logic [NUM_RGN-1:0]     hits,
  input  rgn_cfg_t [NUM_RGN-1:0] cfgs,
  output logic                   rsp_valid,
  output logic                   rsp_allow,
  output logic                   rsp_fault,
  output logic                   rsp_hit,
  output logic [SEL_W-1:0]       rsp_region,
  output logic                   rsp_cacheable,
  output logic                   rsp_bufferable,
  output logic                   rsp_shareable
);

  logic [SEL_W-1:0] win_idx;
  logic             any_hit;
  rgn_cfg_t         wcfg;
  logic             rd_ok, wr_ok, perm;
  logic             allow_c, hit_c;
  logic             cch_c, buf_c, shr_c;

  // highest index wins: later iterations override earlier ones
  always_comb begin
    win_idx = '0;
    any_hit = 1'b0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (hits[i]) begin
        win_idx = SEL_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    wcfg  = cfgs[win_idx];
    rd_ok = ap_read_ok(wcfg.ap, acc_priv);
    wr_ok = ap_write_ok(wcfg.ap, acc_priv);
    perm  = (acc_write ? wr_ok : rd_ok) && (!acc_fetch || (rd_ok && !wcfg.xn));
  end

  always_comb begin
    allow_c = 1'b1;
    hit_c   = 1'b0;
    cch_c   = 1'b0;
    buf_c   = 1'b0;
    shr_c   = 1'b0;
    if (ctrl_en) begin
      if (any_hit) begin
        allow_c = perm;
        hit_c   = 1'b1;
        cch_c   = wcfg.cch;
        buf_c   = wcfg.buf_en;
        shr_c   = wcfg.shr;
      end else begin
        allow_c = acc_priv && ctrl_pdef;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_allow      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_region     <= '0;
      rsp_cacheable  <= 1'b0;
      rsp_bufferable <= 1'b0;
      rsp_shareable  <= 1'b0;
    end else begin
      rsp_valid      <= acc_valid;
      rsp_allow      <= acc_valid && allow_c;
      rsp_fault      <= acc_valid && !allow_c;
      rsp_hit        <= acc_valid && hit_c;
      rsp_region     <= (acc_valid && hit_c) ? win_idx : '0;
      rsp_cacheable  <= acc_valid && cch_c;
      rsp_bufferable <= acc_valid && buf_c;
      rsp_shareable  <= acc_valid && shr_c;
    end
  end

  p_one_verdict_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_allow ^ rsp_fault));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_allow && !rsp_fault && !rsp_hit));

  p_master_off_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !ctrl_en) |=> (rsp_allow && !rsp_hit));

  p_unpriv_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ctrl_en && hits == '0 && !acc_priv) |=> rsp_fault);

  p_top_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ctrl_en && hits[NUM_RGN-1]) |=> (rsp_region == SEL_W'(NUM_RGN-1)));

  p_xn_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ctrl_en && acc_fetch && any_hit && wcfg.xn) |=> rsp_fault);

  p_miss_noattr_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> !(rsp_cacheable || rsp_bufferable || rsp_shareable));

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
  import rgn_guard_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int SEL_W   = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_priv,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_fault,
  output logic              rsp_hit,
  output logic [SEL_W-1:0]  rsp_region,
  output logic              rsp_cacheable,
  output logic              rsp_bufferable,
  output logic              rsp_shareable
);

  logic                   ctrl_en;
  logic                   ctrl_pdef;
  rgn_cfg_t [NUM_RGN-1:0] cfgs;
  logic [NUM_RGN-1:0]     hits;

  rgn_guard_regs #(.NUM_RGN(NUM_RGN), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ctrl_en   (ctrl_en),
    .ctrl_pdef (ctrl_pdef),
    .cfg_o     (cfgs)
  );

  for (genvar i = 0; i < NUM_RGN; i++) begin : g_match
    rgn_guard_match u_match (
      .cfg  (cfgs[i]),
      .addr (acc_addr),
      .hit  (hits[i])
    );
  end

  rgn_guard_decide #(.NUM_RGN(NUM_RGN), .SEL_W(SEL_W)) u_decide (
    .clk            (clk),
    .rst            (rst),
    .acc_valid      (acc_valid),
    .acc_write      (acc_write),
    .acc_fetch      (acc_fetch),
    .acc_priv       (acc_priv),
    .ctrl_en        (ctrl_en),
    .ctrl_pdef      (ctrl_pdef),
    .hits           (hits),
    .cfgs           (cfgs),
    .rsp_valid      (rsp_valid),
    .rsp_allow      (rsp_allow),
    .rsp_fault      (rsp_fault),
    .rsp_hit        (rsp_hit),
    .rsp_region     (rsp_region),
    .rsp_cacheable  (rsp_cacheable),
    .rsp_bufferable (rsp_bufferable),
    .rsp_shareable  (rsp_shareable)
  );

  // R1: nothing is reported in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !rsp_allow && !rsp_fault));

endmodule

// File: tb/rgn_guard_tb.sv
module rgn_guard_tb;

  localparam int NV = 17;
  localparam int VW = 43;

  // {addr, write, fetch, priv, allow, hit, region[2:0], {c,b,s}}
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0800_0000, 3'b000, 1'b1, 1'b1, 3'd0, 3'b111}, // R3 full space, unpriv read on ro/ro
    {32'h0800_0000, 3'b101, 1'b0, 1'b1, 3'd0, 3'b111}, // R6 priv write to ro/ro faults, R9 attrs
    {32'h0800_0000, 3'b010, 1'b1, 1'b1, 3'd0, 3'b111}, // R7 fetch allowed, no XN
    {32'h2000_0100, 3'b000, 1'b1, 1'b1, 3'd1, 3'b111}, // R4 R6 unpriv read on rw/ro
    {32'h2000_0100, 3'b100, 1'b0, 1'b1, 3'd1, 3'b111}, // R6 unpriv write faults
    {32'h2000_0100, 3'b101, 1'b1, 1'b1, 3'd1, 3'b111}, // R6 priv write ok
    {32'h2000_0100, 3'b011, 1'b0, 1'b1, 3'd1, 3'b111}, // R7 XN fetch faults
    {32'h2003_FFFC, 3'b001, 1'b1, 1'b1, 3'd1, 3'b111}, // R3 last word of 256 KiB
    {32'h2004_0000, 3'b000, 1'b1, 1'b1, 3'd0, 3'b111}, // R3 just past window
    {32'h2000_4010, 3'b100, 1'b1, 1'b1, 3'd3, 3'b010}, // R3 masked base, R4 top wins
    {32'h2000_4FF0, 3'b100, 1'b0, 1'b1, 3'd1, 3'b111}, // R5 removed part falls through
    {32'h2000_4DFC, 3'b010, 1'b1, 1'b1, 3'd3, 3'b010}, // R5 part 6 kept
    {32'h2000_5000, 3'b001, 1'b1, 1'b1, 3'd1, 3'b111}, // R3 past 4 KiB window
    {32'h4000_0200, 3'b101, 1'b1, 1'b1, 3'd5, 3'b010}, // R6 rw/none priv write
    {32'h4000_0200, 3'b000, 1'b0, 1'b1, 3'd5, 3'b010}, // R6 rw/none unpriv read
    {32'h4000_0400, 3'b000, 1'b1, 1'b1, 3'd0, 3'b111}, // R3 past 1 KiB window
    {32'h4000_0200, 3'b011, 1'b0, 1'b1, 3'd5, 3'b010}  // R7 XN priv fetch
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_fetch = 1'b0;
  logic        acc_priv = 1'b0;
  logic        rsp_valid, rsp_allow, rsp_fault, rsp_hit;
  logic [2:0]  rsp_region;
  logic        rsp_cacheable, rsp_bufferable, rsp_shareable;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rgn_guard u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .acc_priv(acc_priv),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_cacheable(rsp_cacheable),
    .rsp_bufferable(rsp_bufferable), .rsp_shareable(rsp_shareable)
  );

  function automatic logic [9:0] bus();
    return {rsp_valid, rsp_allow, rsp_fault, rsp_hit, rsp_region,
            rsp_cacheable, rsp_bufferable, rsp_shareable};
  endfunction

  function automatic logic [9:0] ex(input logic al, input logic h,
                                    input logic [2:0] r, input logic [2:0] cbs);
    return {1'b1, al, ~al, h, r, cbs};
  endfunction

  task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic w, input logic f, input logic p);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_fetch = f; acc_priv = p;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset outputs", bus(), 10'b0);

    // R1 R2: control is zero after reset, so everything is allowed
    acc(32'h2000_0100, 1'b1, 1'b0, 1'b0);
    chk("R1 R2 disabled after reset", bus(), ex(1'b1, 1'b0, 3'd0, 3'b000));

    // R10: program windows via select, base and attribute writes
    cfg_wr(2'd1, 32'd0); cfg_wr(2'd2, 32'h0000_0000); cfg_wr(2'd3, 32'h0607_003F);
    cfg_wr(2'd1, 32'd1); cfg_wr(2'd2, 32'h2000_0000); cfg_wr(2'd3, 32'h1207_0023);
    cfg_wr(2'd1, 32'd3); cfg_wr(2'd2, 32'h2000_4123); cfg_wr(2'd3, 32'h0301_8017);
    cfg_wr(2'd1, 32'd5); cfg_wr(2'd2, 32'h4000_0000); cfg_wr(2'd3, 32'h1101_0013);
    cfg_wr(2'd0, 32'd3);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      acc(v[42:11], v[10], v[9], v[8]);
      chk($sformatf("R3 R4 R5 R6 R7 R9 R10 vector %0d", i), bus(),
          ex(v[7], v[6], v[5:3], v[2:0]));
    end

    // R11: attribute write and access in the same cycle (select is still 5)
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'h1301_0013;
    acc_valid = 1'b1; acc_addr = 32'h4000_0200; acc_write = 1'b0;
    acc_fetch = 1'b0; acc_priv = 1'b0;
    @(posedge clk); #1;
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk("R11 same-cycle uses old rights", bus(), ex(1'b0, 1'b1, 3'd5, 3'b010));
    acc(32'h4000_0200, 1'b0, 1'b0, 1'b0);
    chk("R11 next cycle uses new rights", bus(), ex(1'b1, 1'b1, 3'd5, 3'b010));

    // R8: remove the full-space window so an address misses
    cfg_wr(2'd1, 32'd0); cfg_wr(2'd3, 32'h0);
    acc(32'h6000_0000, 1'b0, 1'b0, 1'b1);
    chk("R8 priv miss default on", bus(), ex(1'b1, 1'b0, 3'd0, 3'b000));
    acc(32'h6000_0000, 1'b0, 1'b1, 1'b1);
    chk("R8 priv fetch miss default on", bus(), ex(1'b1, 1'b0, 3'd0, 3'b000));
    acc(32'h6000_0000, 1'b0, 1'b0, 1'b0);
    chk("R8 unpriv miss faults", bus(), ex(1'b0, 1'b0, 3'd0, 3'b000));
    cfg_wr(2'd0, 32'd1);
    acc(32'h6000_0000, 1'b0, 1'b0, 1'b1);
    chk("R8 priv miss default off", bus(), ex(1'b0, 1'b0, 3'd0, 3'b000));

    // R2: master off overrides a window that would refuse
    cfg_wr(2'd0, 32'd0);
    acc(32'h2000_0100, 1'b1, 1'b0, 1'b0);
    chk("R2 master off allows", bus(), ex(1'b1, 1'b0, 3'd0, 3'b000));

    // R12: idle cycle
    @(posedge clk); #1;
    chk("R12 idle outputs", bus(), 10'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule